// File: doc/BRIEF.md
# Address Region Decoder with Boot Remap

This block takes a 32-bit byte address from a CPU request and resolves it to one target region: the flash array, the SRAM array, one of four external 64 kB windows, or the peripheral register space at the top of the address map. The lowest 64 kB of the map is an alias window. A one-bit remap control picks whether the window shows the flash array or the SRAM array. The control comes out of reset pointing at flash, so the processor boots from nonvolatile code. Software can later switch the window to SRAM so that vectors and hot code run from RAM.

For each accepted request the block returns a one-hot target select, the byte offset inside the target, a decode-error flag for addresses in reserved gaps, and the number of cycles the access takes. The access completes in one cycle when the target sits on the fast system bus and in two cycles when it sits on the peripheral bus. The CPU holds `req_valid` and the address until it sees `req_ready`. Only one request is in flight at a time.

Top module: `memmap_decode`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `req_ready` is 0, `tgt_sel` is 0 and `dec_err` is 0. The remap control resets to 1.
- R2: With the remap control at 1, addresses 0x00000000 to 0x0000FFFF select flash (`tgt_sel` bit 0) with offset equal to address bits 15:0.
- R3: With the remap control at 0, low-window addresses 0x00000000 to 0x00001FFF select SRAM (`tgt_sel` bit 1) with offset equal to address bits 12:0. Low-window addresses 0x00002000 to 0x0000FFFF are a decode error.
- R4: SRAM decodes at 0x00010000 to 0x00011FFF (bit 1) and flash at 0x00080000 to 0x0008FFFF (bit 0), each with its offset inside the region.
- R5: The external windows at 0x10000000, 0x20000000, 0x30000000 and 0x40000000 are 64 kB each and select `tgt_sel` bits 2, 3, 4 and 5 respectively, with offset equal to address bits 15:0.
- R6: Addresses 0xFFFF0000 to 0xFFFFFFFF select the peripheral space (`tgt_sel` bit 6) with offset equal to address bits 15:0.
- R7: Any other address sets `dec_err` to 1, `tgt_sel` to 0 and `tgt_offset` to 0.
- R8: Some targets are fast: flash, SRAM, decode errors and the two fast peripheral windows at 0xFFFFF400 to 0xFFFFF4FF and 0xFFFFFC00 to 0xFFFFFCFF. For these, `wait_cycles` is 1 and `req_ready` rises in the cycle after the accepting edge. External windows and all other peripheral addresses have `wait_cycles` of 2, and `req_ready` rises one cycle later.
- R9: `tgt_sel` is never more than one-hot.
- R10: A `remap_wr` pulse loads `remap_wdata` into the remap control. An access accepted on the same edge as the write, or already pending when it lands, keeps the decode made with the old value. The next access uses the new value.
- R11: The outputs hold from acceptance until `req_ready`. `req_ready` is high for exactly one cycle. The block is idle in the cycle after it, and a new request is accepted only from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request, held until `req_ready` |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | One-cycle completion pulse |
| remap_wr | input | 1 | Write strobe for the remap control |
| remap_wdata | input | 1 | New remap value: 1 = low window shows flash, 0 = SRAM |
| tgt_sel | output | 7 | One-hot target: 0 flash, 1 SRAM, 2..5 external 0..3, 6 peripherals |
| tgt_offset | output | 16 | Byte offset inside the selected target |
| dec_err | output | 1 | Address falls in reserved space |
| wait_cycles | output | 2 | Access latency in cycles, 1 or 2 |

## Verification
The checker assumes the CPU side behaves correctly. `req_valid` and `req_addr` stay constant from the accepting edge until the edge after `req_ready`, and `req_valid` then drops. Under that assumption, the decoded outputs are held while a request is pending and `req_ready` is a single pulse. The bench drives every request from a task that raises `req_valid` at a falling edge, waits for `req_ready`, and drops the request at once. `remap_wr` pulses are issued only on the accepting edge or during a pending slow access, so each pulse's effect can be attributed to a specific access.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W = 32;
  localparam int TGT_N  = 7;

  localparam int TGT_FLASH = 0;
  localparam int TGT_SRAM  = 1;
  localparam int TGT_EXT0  = 2;
  localparam int TGT_PERIF = 6;

  // Region table, index 0 in the rightmost slot
  localparam logic [TGT_N-1:0][ADDR_W-1:0] TGT_BASE = {
    32'hFFFF_0000, 32'h4000_0000, 32'h3000_0000, 32'h2000_0000,
    32'h1000_0000, 32'h0001_0000, 32'h0008_0000};
  localparam logic [TGT_N-1:0][ADDR_W-1:0] TGT_SIZE = {
    32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000,
    32'h0001_0000, 32'h0000_2000, 32'h0001_0000};
  // External windows always go through the slow path
  localparam logic [TGT_N-1:0] TGT_SLOW = 7'b011_1100;

  localparam logic [ADDR_W-1:0] LOW_LIMIT = 32'h0001_0000;

  // Peripheral windows reached over the fast system bus
  localparam int FASTWIN_N = 2;
  localparam logic [FASTWIN_N-1:0][ADDR_W-1:0] FASTWIN_BASE = {
    32'hFFFF_FC00, 32'hFFFF_F400};
  localparam logic [ADDR_W-1:0] FASTWIN_SIZE = 32'h0000_0100;
endpackage

// File: rtl/memmap_region_match.sv
module memmap_region_match #(
  parameter int          ADDR_W = 32,
  parameter int          OFS_W  = 16,
  parameter logic [31:0] BASE   = 32'h0,
  parameter logic [31:0] SIZE   = 32'h1_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(SIZE - 32'd1);
  localparam logic [ADDR_W-1:0] HIGH_MASK = ~LOW_MASK;

  always_comb begin
    hit = ((addr & HIGH_MASK) == ADDR_W'(BASE));
    ofs = addr[OFS_W-1:0] & LOW_MASK[OFS_W-1:0];
  end
endmodule

// File: rtl/memmap_decode_core.sv
module memmap_decode_core
  import memmap_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int WAIT_W    = 2,
  parameter int FAST_WAIT = 1,
  parameter int SLOW_WAIT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  output logic [TGT_N-1:0]  sel,
  output logic [OFS_W-1:0]  ofs,
  output logic              err,
  output logic [WAIT_W-1:0] wait_n
);
  localparam logic [ADDR_W-1:0] SRAM_LIMIT = TGT_SIZE[TGT_SRAM];
  localparam logic [ADDR_W-1:0] FW_HIGH    = ~(FASTWIN_SIZE - 32'd1);

  logic [TGT_N-1:0] hit;
  logic [OFS_W-1:0] reg_ofs [TGT_N];

  for (genvar g = 0; g < TGT_N; g++) begin : g_rgn
    memmap_region_match #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W),
      .BASE(TGT_BASE[g]), .SIZE(TGT_SIZE[g])
    ) u_match (
      .addr(addr), .hit(hit[g]), .ofs(reg_ofs[g])
    );
  end

  logic fast_win;
  always_comb begin
    fast_win = 1'b0;
    for (int i = 0; i < FASTWIN_N; i++)
      fast_win = fast_win | ((addr & FW_HIGH) == FASTWIN_BASE[i]);
  end

  logic low_hit;
  assign low_hit = (addr < LOW_LIMIT);

  always_comb begin
    sel = '0;
    ofs = '0;
    err = 1'b0;
    if (low_hit) begin
      if (remap) begin
        sel[TGT_FLASH] = 1'b1;
        ofs            = addr[OFS_W-1:0];
      end else if (addr < SRAM_LIMIT) begin
        sel[TGT_SRAM] = 1'b1;
        ofs           = addr[OFS_W-1:0];
      end else begin
        err = 1'b1;
      end
    end else if (|hit) begin
      sel = hit;
      for (int i = 0; i < TGT_N; i++)
        if (hit[i]) ofs = ofs | reg_ofs[i];
    end else begin
      err = 1'b1;
    end
  end

  always_comb begin
    if (|(sel & TGT_SLOW) || (sel[TGT_PERIF] && !fast_win))
      wait_n = WAIT_W'(SLOW_WAIT);
    else
      wait_n = WAIT_W'(FAST_WAIT);
  end
endmodule

// File: rtl/memmap_access_ctrl.sv
module memmap_access_ctrl #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              busy,
  output logic              ready,
  output logic              accept
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              busy_d;

  assign accept = valid && !busy;
  assign ready  = busy && (cnt_q == '0);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = wait_in - WAIT_W'(1);
    end else if (busy && cnt_q != '0) begin
      cnt_d = cnt_q - WAIT_W'(1);
    end else if (ready) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int WAIT_W    = 2,
  parameter int FAST_WAIT = 1,
  parameter int SLOW_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              req_ready,
  input  logic              remap_wr,
  input  logic              remap_wdata,
  output logic [6:0]        tgt_sel,
  output logic [OFS_W-1:0]  tgt_offset,
  output logic              dec_err,
  output logic [WAIT_W-1:0] wait_cycles
);
  logic remap_q, remap_d;

  logic [TGT_N-1:0]  sel_c;
  logic [OFS_W-1:0]  ofs_c;
  logic              err_c;
  logic [WAIT_W-1:0] wait_c;

  logic busy, accept;

  memmap_decode_core #(
    .OFS_W(OFS_W), .WAIT_W(WAIT_W),
    .FAST_WAIT(FAST_WAIT), .SLOW_WAIT(SLOW_WAIT)
  ) u_core (
    .addr(req_addr), .remap(remap_q),
    .sel(sel_c), .ofs(ofs_c), .err(err_c), .wait_n(wait_c)
  );

  memmap_access_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .wait_in(wait_c),
    .busy(busy), .ready(req_ready), .accept(accept)
  );

  // Remap control: clock enable is the write strobe
  assign remap_d = remap_wr ? remap_wdata : remap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remap_q <= 1'b1;
    else        remap_q <= remap_d;
  end

  // Decode result captured on acceptance, held until completion
  logic [TGT_N-1:0]  sel_d;
  logic [OFS_W-1:0]  ofs_d;
  logic              err_d;
  logic [WAIT_W-1:0] wait_d;

  always_comb begin
    sel_d  = tgt_sel;
    ofs_d  = tgt_offset;
    err_d  = dec_err;
    wait_d = wait_cycles;
    if (accept) begin
      sel_d  = sel_c;
      ofs_d  = ofs_c;
      err_d  = err_c;
      wait_d = wait_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_sel     <= '0;
      tgt_offset  <= '0;
      dec_err     <= 1'b0;
      wait_cycles <= '0;
    end else begin
      tgt_sel     <= sel_d;
      tgt_offset  <= ofs_d;
      dec_err     <= err_d;
      wait_cycles <= wait_d;
    end
  end
endmodule

// File: rtl/memmap_decode_chk.sv
module memmap_decode_chk #(
  parameter int OFS_W     = 16,
  parameter int WAIT_W    = 2,
  parameter int FAST_WAIT = 1,
  parameter int SLOW_WAIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic [6:0]        tgt_sel,
  input logic [OFS_W-1:0]  tgt_offset,
  input logic              dec_err,
  input logic [WAIT_W-1:0] wait_cycles
);
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  assert_err_no_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (tgt_sel == '0 && tgt_offset == '0));

  assert_ready_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_hold_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_ready) |=> ($stable(tgt_sel) && $stable(tgt_offset)
                              && $stable(dec_err) && $stable(wait_cycles)));

  assert_wait_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (wait_cycles == WAIT_W'(FAST_WAIT) || wait_cycles == WAIT_W'(SLOW_WAIT)));

  assert_slow_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && wait_cycles == WAIT_W'(SLOW_WAIT)) |-> $past(busy && !req_ready));
endmodule

bind memmap_decode memmap_decode_chk #(
  .OFS_W(OFS_W), .WAIT_W(WAIT_W), .FAST_WAIT(FAST_WAIT), .SLOW_WAIT(SLOW_WAIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .dec_err(dec_err),
  .wait_cycles(wait_cycles)
);

// File: tb/memmap_decode_tb_top.sv
module memmap_decode_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        remap_wr;
  logic        remap_wdata;
  logic [6:0]  tgt_sel;
  logic [15:0] tgt_offset;
  logic        dec_err;
  logic [1:0]  wait_cycles;

  int n_checks;
  int n_fails;
  int cycles;

  memmap_decode dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .remap_wr(remap_wr), .remap_wdata(remap_wdata),
    .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .dec_err(dec_err),
    .wait_cycles(wait_cycles)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [6:0]  sel;
    logic [15:0] ofs;
    logic        err;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 20;
  // Remap control at its reset value 1
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 7'h01, 16'h0000, 1'b0, 2'd1},  // R2
    '{32'h0000_FFFF, 7'h01, 16'hFFFF, 1'b0, 2'd1},  // R2
    '{32'h0001_0000, 7'h02, 16'h0000, 1'b0, 2'd1},  // R4
    '{32'h0001_1FFF, 7'h02, 16'h1FFF, 1'b0, 2'd1},  // R4
    '{32'h0001_2000, 7'h00, 16'h0000, 1'b1, 2'd1},  // R7
    '{32'h0007_FFFF, 7'h00, 16'h0000, 1'b1, 2'd1},  // R7
    '{32'h0008_0000, 7'h01, 16'h0000, 1'b0, 2'd1},  // R4
    '{32'h0008_ABCD, 7'h01, 16'hABCD, 1'b0, 2'd1},  // R4
    '{32'h0009_0000, 7'h00, 16'h0000, 1'b1, 2'd1},  // R7
    '{32'h1000_0010, 7'h04, 16'h0010, 1'b0, 2'd2},  // R5
    '{32'h2000_FFFF, 7'h08, 16'hFFFF, 1'b0, 2'd2},  // R5
    '{32'h3000_1234, 7'h10, 16'h1234, 1'b0, 2'd2},  // R5
    '{32'h4000_8000, 7'h20, 16'h8000, 1'b0, 2'd2},  // R5
    '{32'h4001_0000, 7'h00, 16'h0000, 1'b1, 2'd1},  // R7
    '{32'hFFFF_0040, 7'h40, 16'h0040, 1'b0, 2'd2},  // R6
    '{32'hFFFF_F404, 7'h40, 16'hF404, 1'b0, 2'd1},  // R8 fast window
    '{32'hFFFF_FC10, 7'h40, 16'hFC10, 1'b0, 2'd1},  // R8 fast window
    '{32'hFFFF_F800, 7'h40, 16'hF800, 1'b0, 2'd2},  // R8 slow
    '{32'hFFFE_FFFF, 7'h00, 16'h0000, 1'b1, 2'd1},  // R7
    '{32'h5000_0000, 7'h00, 16'h0000, 1'b1, 2'd1}   // R7
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // wr_at_accept: remap write on the accepting edge; wr_mid: during pending
  task automatic access(input string req, input vec_t v,
                        input bit wr_at_accept, input bit wr_mid, input bit wval);
    int lat;
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = v.addr;
    remap_wr    = wr_at_accept;
    remap_wdata = wval;
    lat = 0;
    while (lat < 8) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      remap_wr = (wr_mid && lat == 1 && !req_ready);
      if (req_ready) break;
    end
    remap_wr = 1'b0;
    check(req, "latency",  32'(lat),         32'(v.lat));
    check(req, "wait",     32'(wait_cycles), 32'(v.lat));
    check(req, "sel",      32'(tgt_sel),     32'(v.sel));
    check(req, "offset",   32'(tgt_offset),  32'(v.ofs));
    check(req, "err",      32'(dec_err),     32'(v.err));
    req_valid = 1'b0;
    @(negedge clk);
    check("R11", "ready after completion", 32'(req_ready), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; cycles = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    remap_wr = 1'b0; remap_wdata = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ready in reset", 32'(req_ready), 32'd0);
    check("R1", "sel in reset",   32'(tgt_sel),   32'd0);
    check("R1", "err in reset",   32'(dec_err),   32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after release", 32'(req_ready), 32'd0);

    for (int i = 0; i < NV; i++) access("R2-table", VECS[i], 1'b0, 1'b0, 1'b0);

    // R10: write 0 on accepting edge, this access still sees flash
    access("R10", '{32'h0000_0100, 7'h01, 16'h0100, 1'b0, 2'd1}, 1'b1, 1'b0, 1'b0);
    // R3: next accesses see SRAM in the low window
    access("R3", '{32'h0000_0100, 7'h02, 16'h0100, 1'b0, 2'd1}, 1'b0, 1'b0, 1'b0);
    access("R3", '{32'h0000_1FFF, 7'h02, 16'h1FFF, 1'b0, 2'd1}, 1'b0, 1'b0, 1'b0);
    access("R3", '{32'h0000_2000, 7'h00, 16'h0000, 1'b1, 2'd1}, 1'b0, 1'b0, 1'b0);
    access("R3", '{32'h0000_FFFF, 7'h00, 16'h0000, 1'b1, 2'd1}, 1'b0, 1'b0, 1'b0);
    // R10: write 1 while a slow access is pending, outputs unchanged
    access("R10", '{32'h2000_0044, 7'h08, 16'h0044, 1'b0, 2'd2}, 1'b0, 1'b1, 1'b1);
    access("R10", '{32'h0000_2000, 7'h01, 16'h2000, 1'b0, 2'd1}, 1'b0, 1'b0, 1'b0);

    // R1: reset restores remap to flash
    @(negedge clk);
    remap_wr = 1'b1; remap_wdata = 1'b0;
    @(negedge clk);
    remap_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access("R1", '{32'h0000_0008, 7'h01, 16'h0008, 1'b0, 2'd1}, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule